// File: doc/BRIEF.md
# Bus Frame Timer with Suspend Escalation

This block watches the timing of start-of-frame packets on a full-speed serial bus. The host sends one such packet every millisecond. The packet decoder pulses `sof_i` for each packet it receives and `traffic_i` for any other bus activity. The block then produces per-frame event pulses for the interrupt logic.

An interval counter runs on the local clock and restarts at each start-of-frame packet. If the counter reaches the nominal period plus a tolerance margin and no packet has arrived, the block flags a missed frame and restarts the count for the next expected frame. Missed frames are flagged whether or not the timer is locked. The lock flag is set when two packets arrive one period apart, within the tolerance.

A run of missed frames with no bus activity between them means the host has gone quiet. After the third such miss in a row, the block issues a one-cycle suspend request. Decoding the frame number and recovering the clock are left to other blocks.

Top module: `usb_frame_timer`

## Requirements
- R1: `sof_evt_o` pulses high for exactly the cycle after each cycle in which `sof_i` is sampled high.
- R2: The interval count is 1 after reset, after a start-of-frame packet and after a miss. It increases by one on each other cycle. When the count equals FRAME_LEN+TOL and `sof_i` is low, `esof_evt_o` pulses one cycle later and the count restarts.
- R3: Missed frames are flagged the same way whether `locked_o` is high or low, including from reset before any packet has been seen.
- R4: A cycle with `sof_i` or `traffic_i` high clears the consecutive-miss count. A miss in that same cycle is still flagged, but it does not count toward suspend.
- R5: `suspend_o` pulses for one cycle, together with `esof_evt_o`, on the third consecutive miss. The miss count then saturates, so later misses produce no further suspend pulse until the count is cleared.
- R6: `locked_o` is set one cycle after a start-of-frame packet that arrives at an interval count within [FRAME_LEN-TOL, FRAME_LEN+TOL], provided an earlier packet has been seen since reset or since the last miss.
- R7: A miss clears `locked_o` and forgets the previous packet. A packet that arrives outside the window also clears `locked_o`, but it counts as the new reference packet.
- R8: Synchronous active-high `rst` clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Start-of-frame packet received (one-cycle pulse) |
| traffic_i | input | 1 | Other bus traffic seen (one-cycle pulse) |
| sof_evt_o | output | 1 | Start-of-frame event pulse |
| esof_evt_o | output | 1 | Missed-frame event pulse |
| suspend_o | output | 1 | Suspend request pulse |
| locked_o | output | 1 | Timer locked to host frame timing |

## Verification
A wrong interval count shows up as `esof_evt_o` firing on the wrong cycle. The error therefore appears within one frame limit after the last packet or miss. A wrong miss count shows up as a suspend pulse on the wrong miss, or as a repeated pulse, so the error is visible within three frame limits of silence. A wrong lock state shows on `locked_o` one cycle after the next packet or miss. The bench compares every output on every cycle, so each divergence is reported in the cycle where it first appears.

// File: rtl/usb_ft_pkg.sv
package usb_ft_pkg;
  localparam int unsigned MISS_RUN_DEFAULT = 3;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/ft_interval_ctr.sv
module ft_interval_ctr #(
  parameter int unsigned FRAME_LEN = 48000,
  parameter int unsigned TOL       = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic sof_i,
  output logic miss_now_o,
  output logic in_win_o
);
  localparam int unsigned LIMIT = FRAME_LEN + TOL;
  localparam int unsigned LOWER = FRAME_LEN - TOL;
  localparam int unsigned W     = usb_ft_pkg::cnt_width(LIMIT);

  logic [W-1:0] cnt_q;

  assign miss_now_o = (cnt_q == W'(LIMIT)) && !sof_i;
  assign in_win_o   = (cnt_q >= W'(LOWER)) && (cnt_q <= W'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || sof_i || miss_now_o) cnt_q <= W'(1);
    else                            cnt_q <= cnt_q + W'(1);
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q >= W'(1)) && (cnt_q <= W'(LIMIT)));
endmodule

// File: rtl/ft_lock_trk.sv
module ft_lock_trk (
  input  logic clk,
  input  logic rst,
  input  logic sof_i,
  input  logic miss_i,
  input  logic in_win_i,
  output logic locked_o
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst || miss_i) begin
      seen_q   <= 1'b0;
      locked_o <= 1'b0;
    end else if (sof_i) begin
      seen_q   <= 1'b1;
      locked_o <= seen_q && in_win_i;
    end
  end

  // R7
  lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
    miss_i |=> !locked_o);
endmodule

// File: rtl/ft_miss_esc.sv
module ft_miss_esc #(
  parameter int unsigned MISS_RUN = usb_ft_pkg::MISS_RUN_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic miss_i,
  output logic esof_o,
  output logic susp_o
);
  localparam int unsigned MW = usb_ft_pkg::cnt_width(MISS_RUN);

  logic [MW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      esof_o <= 1'b0;
      susp_o <= 1'b0;
    end else begin
      esof_o <= miss_i;
      susp_o <= miss_i && !clr_i && (run_q == MW'(MISS_RUN - 1));
      if (clr_i)                                 run_q <= '0;
      else if (miss_i && run_q != MW'(MISS_RUN)) run_q <= run_q + MW'(1);
    end
  end

  // R5
  susp_single_chk: assert property (@(posedge clk) disable iff (rst)
    susp_o |=> !susp_o);
  // R4
  clr_no_susp_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !susp_o);
  // R5
  run_sat_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= MW'(MISS_RUN));
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int unsigned FRAME_LEN = 48000,
  parameter int unsigned TOL       = 48,
  parameter int unsigned MISS_RUN  = usb_ft_pkg::MISS_RUN_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic sof_i,
  input  logic traffic_i,
  output logic sof_evt_o,
  output logic esof_evt_o,
  output logic suspend_o,
  output logic locked_o
);
  logic miss_now, in_win;

  ft_interval_ctr #(.FRAME_LEN(FRAME_LEN), .TOL(TOL)) u_ctr (
    .clk(clk), .rst(rst), .sof_i(sof_i),
    .miss_now_o(miss_now), .in_win_o(in_win));

  ft_lock_trk u_lock (
    .clk(clk), .rst(rst), .sof_i(sof_i), .miss_i(miss_now),
    .in_win_i(in_win), .locked_o(locked_o));

  ft_miss_esc #(.MISS_RUN(MISS_RUN)) u_esc (
    .clk(clk), .rst(rst), .clr_i(sof_i | traffic_i), .miss_i(miss_now),
    .esof_o(esof_evt_o), .susp_o(suspend_o));

  always_ff @(posedge clk) begin
    if (rst) sof_evt_o <= 1'b0;
    else     sof_evt_o <= sof_i;
  end

  // R1
  sof_evt_chk: assert property (@(posedge clk) disable iff (rst)
    sof_i |=> sof_evt_o);
  // R5
  susp_with_esof_chk: assert property (@(posedge clk) disable iff (rst)
    suspend_o |-> esof_evt_o);
  // R2
  esof_not_sof_chk: assert property (@(posedge clk) disable iff (rst)
    esof_evt_o |-> !sof_evt_o);
endmodule

// File: tb/sim_usb_frame_timer.sv
module sim_usb_frame_timer;
  localparam int unsigned F   = 40;
  localparam int unsigned T   = 3;
  localparam int unsigned LIM = F + T;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sof_i = 1'b0, traffic_i = 1'b0;
  logic sof_evt_o, esof_evt_o, suspend_o, locked_o;

  int checks = 0, errors = 0;
  int m_cnt = 1, m_run = 0;
  bit m_seen = 0;
  bit e_sof = 0, e_esof = 0, e_susp = 0, e_lock = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_frame_timer #(.FRAME_LEN(F), .TOL(T)) u0 (
    .clk(clk), .rst(rst), .sof_i(sof_i), .traffic_i(traffic_i),
    .sof_evt_o(sof_evt_o), .esof_evt_o(esof_evt_o),
    .suspend_o(suspend_o), .locked_o(locked_o));

  function automatic bit in_window(input int c);
    return (c >= int'(F - T)) && (c <= int'(LIM));
  endfunction

  // Reference model built from the requirements
  always @(posedge clk) begin
    bit miss;
    if (rst) begin
      m_cnt = 1; m_run = 0; m_seen = 0;
      e_sof = 0; e_esof = 0; e_susp = 0; e_lock = 0;
    end else begin
      miss   = (m_cnt == int'(LIM)) && !sof_i;
      e_sof  = sof_i;
      e_esof = miss;
      e_susp = miss && !(sof_i || traffic_i) && (m_run == 2);
      if (miss) begin e_lock = 0; m_seen = 0; end
      else if (sof_i) begin e_lock = m_seen && in_window(m_cnt); m_seen = 1; end
      if (sof_i || traffic_i) m_run = 0;
      else if (miss && m_run < 3) m_run++;
      m_cnt = (sof_i || miss) ? 1 : m_cnt + 1;
    end
  end

  task automatic chk(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
    end
  endtask

  // Compare every cycle at the falling edge
  always @(negedge clk) if (!done) begin
    chk(sof_evt_o,  e_sof,  rst ? "R8 sof_evt" : "R1 sof_evt");
    chk(esof_evt_o, e_esof, rst ? "R8 esof" : "R2/R3 esof");
    chk(suspend_o,  e_susp, rst ? "R8 suspend" : "R4/R5 suspend");
    chk(locked_o,   e_lock, rst ? "R8 locked" : "R6/R7 locked");
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sof_i = 0; traffic_i = 0;
    end
  endtask

  task automatic pulse_sof();
    @(negedge clk); sof_i = 1; traffic_i = 0;
    @(negedge clk); sof_i = 0;
  endtask

  task automatic pulse_traffic();
    @(negedge clk); traffic_i = 1; sof_i = 0;
    @(negedge clk); traffic_i = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R3: misses from reset before any packet; R5: suspend on the third, saturated afterwards
    idle(6 * LIM);
    // R4: traffic breaks the miss run
    pulse_traffic();
    idle(2 * LIM);
    pulse_traffic();
    idle(4 * LIM);
    // R6: two packets one period apart lock; edges of the window
    pulse_sof(); idle(F - 2);
    pulse_sof(); idle(F + T - 2);
    pulse_sof(); idle(F - T - 2);
    pulse_sof(); idle(F - T - 3);
    // R7: packet outside the window clears lock
    pulse_sof(); idle(F - 2);
    pulse_sof(); idle(3 * LIM);
    // Constrained random phases
    for (int ph = 0; ph < 300; ph++) begin
      int gap;
      if ($urandom_range(0, 9) == 0) gap = $urandom_range(LIM, 4 * LIM);
      else gap = int'(F) + $urandom_range(0, 2 * T + 4) - int'(T) - 2;
      for (int c = 0; c < gap - 1; c++) begin
        @(negedge clk); sof_i = 0;
        traffic_i = ($urandom_range(0, 99) == 0);
      end
      @(negedge clk); sof_i = 1; traffic_i = 0;
    end
    @(negedge clk); sof_i = 0;
    // R8: reset mid-run
    idle(10);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    idle(4 * LIM);
    @(negedge clk); done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    done = 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule